// File: doc/BRIEF.md
# Scanline NMI Pulse Generator

This block raises the non-maskable interrupt request of a display controller. Two sources can request it: a display-list interrupt and a vertical-blank interrupt. Both are gated by one shared trigger window, which is decoded from the horizontal beam counter. The comparator that makes the window ignores bit 0 of the counter, so the window always spans two consecutive counts.

In each cycle of the window, every pending source is ANDed with its own bit of a CPU-writable enable register, and the result drives a registered, active-low NMI line. The enable register is read live on every cycle, so a write that lands between the two window cycles can shorten the pulse to a single cycle. A status register records which source reached the window, whether or not that source was enabled. A write to the status-reset address clears it.

Top module: `nmi_pulse_gen`

## Requirements
- R1: After reset, nmi_n is 1, nmi_status is 0 and both enable bits are 0, so an active source makes no pulse until it is enabled.
- R2: The trigger window is open while hcount with bit 0 ignored equals TRIG_POS (default 6, so counts 6 and 7). With a source active and enabled across the whole line, nmi_n is low for exactly two cycles.
- R3: nmi_n is low in the cycle after a cycle where the window is open and at least one source is active with its enable bit set. Both sources (dli_req, vbl_req) share the same window.
- R4: A write with wr_sel=0 loads the enable register from wr_data: bit 1 enables the display-list source and bit 0 enables the vertical-blank source. The new value governs the cycles after the write cycle, including the second cycle of a window that is already open.
- R5: With the source enabled, a disabling write in the cycle with hcount=5 suppresses the NMI entirely. The same write at hcount=6 leaves a pulse one cycle long.
- R6: With the source disabled, an enabling write at hcount=6 produces a pulse one cycle long. The same write at hcount=7 or later produces no pulse on that line.
- R7: nmi_status bit 1 (display list) and bit 0 (vertical blank) are set in the cycle after a window cycle in which that source is active, whatever the enable bits hold.
- R8: A write with wr_sel=1 clears nmi_status from the next cycle, ignores wr_data and leaves the enable register unchanged. A bit being set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | HC_W | Horizontal beam counter |
| dli_req | input | 1 | Display-list interrupt pending |
| vbl_req | input | 1 | Vertical-blank interrupt pending |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = enable register, 1 = status reset |
| wr_data | input | NSRC | Write data (bit 1 display list, bit 0 vertical blank) |
| nmi_n | output | 1 | Active-low NMI request, registered |
| nmi_status | output | NSRC | Sources that have reached the window since the last clear |

## Verification
A window decoder that compared bit 0 would show up at once: on the first enabled line, nmi_n would be low for one cycle or for none instead of two. A stale or wrongly latched enable bit changes the pulse length on the very line of the write. That is why the bench moves an enabling or disabling write across every count around the window and counts the low cycles. A status bit that is wrong, set too early or cleared too late shows on nmi_status one cycle after the window or after the clear write.

// File: rtl/nmi_pulse_pkg.sv
package nmi_pulse_pkg;

  localparam int NSRC    = 2;
  localparam int SRC_VBL = 0;
  localparam int SRC_DLI = 1;

  // Trigger window: counter and position compared with bit 0 dropped.
  function automatic logic in_pair_window(input logic [15:0] h,
                                          input logic [15:0] pos);
    return (h >> 1) == (pos >> 1);
  endfunction

  // Next status: newly seen sources always stick, a clear drops the rest.
  function automatic logic [NSRC-1:0] next_status(input logic [NSRC-1:0] cur,
                                                  input logic [NSRC-1:0] seen,
                                                  input logic            clr);
    return clr ? seen : (cur | seen);
  endfunction

endpackage

// File: rtl/nmi_trig_decode.sv
module nmi_trig_decode #(
  parameter int HC_W     = 8,
  parameter int TRIG_POS = 6
) (
  input  logic [HC_W-1:0] hcount,
  output logic            win
);
  import nmi_pulse_pkg::*;

  localparam logic [15:0] POS16 = 16'(TRIG_POS);

  always_comb win = in_pair_window(16'(hcount), POS16);

endmodule

// File: rtl/nmi_enable_reg.sv
module nmi_enable_reg #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] en_q
);
  logic load_en;
  always_comb load_en = wr_en && !wr_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (load_en) en_q <= wr_data;
  end

  // R4
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> en_q == $past(wr_data));

  // R8
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(en_q));

endmodule

// File: rtl/nmi_status_reg.sv
module nmi_status_reg #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] seen,
  input  logic            clr,
  output logic [NSRC-1:0] st_q
);
  import nmi_pulse_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= next_status(st_q, seen, clr);
  end

  // R8
  st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && seen == '0) |=> st_q == '0);

  // R7
  st_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (st_q & $past(st_q)) == $past(st_q));

endmodule

// File: rtl/nmi_line_drive.sv
module nmi_line_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_any,
  output logic nmi_n
);
  logic nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) nmi_q <= 1'b0;
    else        nmi_q <= fire_any;
  end

  always_comb nmi_n = !nmi_q;

endmodule

// File: rtl/nmi_pulse_gen.sv
module nmi_pulse_gen #(
  parameter int HC_W     = 8,
  parameter int TRIG_POS = 6,
  parameter int NSRC     = nmi_pulse_pkg::NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HC_W-1:0] hcount,
  input  logic            dli_req,
  input  logic            vbl_req,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [NSRC-1:0] wr_data,
  output logic            nmi_n,
  output logic [NSRC-1:0] nmi_status
);
  import nmi_pulse_pkg::*;

  logic            win;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] seen;
  logic [NSRC-1:0] fire;
  logic            fire_any;
  logic            st_clr;

  always_comb begin
    src          = '0;
    src[SRC_VBL] = vbl_req;
    src[SRC_DLI] = dli_req;
  end

  always_comb st_clr = wr_en && wr_sel;

  nmi_trig_decode #(.HC_W(HC_W), .TRIG_POS(TRIG_POS)) i_trig (
    .hcount (hcount),
    .win    (win)
  );

  nmi_enable_reg #(.NSRC(NSRC)) i_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .en_q    (en_q)
  );

  // Each source is gated by the shared window; status ignores the enables.
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb seen[i] = win && src[i];
    always_comb fire[i] = seen[i] && en_q[i];
  end

  always_comb fire_any = |fire;

  nmi_status_reg #(.NSRC(NSRC)) i_st (
    .clk   (clk),
    .rst_n (rst_n),
    .seen  (seen),
    .clr   (st_clr),
    .st_q  (nmi_status)
  );

  nmi_line_drive i_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_any (fire_any),
    .nmi_n    (nmi_n)
  );

  // R3
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |-> $past(win && (src & en_q) != '0));

  // R2
  nmi_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win) |-> nmi_n);

  // R7
  for (genvar k = 0; k < NSRC; k++) begin : g_stchk
    // R7
    st_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_status[k]) |-> $past(win && src[k]));
  end

endmodule

// File: tb/test_nmi_pulse_gen.sv
`timescale 1ns/1ps
module test_nmi_pulse_gen;

  localparam int TRIG  = 6;
  localparam int LINE  = 114;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hcount = '0;
  logic       dli_req = 1'b0, vbl_req = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [1:0] wr_data = '0;
  logic       nmi_n;
  logic [1:0] nmi_status;

  int errors = 0, checks = 0, low_cnt = 0;
  logic [1:0] en_m = '0, st_m = '0;

  always #2 clk = !clk;

  nmi_pulse_gen i_nmi_pulse_gen (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .dli_req(dli_req),
    .vbl_req(vbl_req), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nmi_n(nmi_n), .nmi_status(nmi_status)
  );

  function automatic bit win_at(input int h);
    return (h / 2) == (TRIG / 2);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, check at the next negedge.
  task automatic cyc(input int h, input logic [1:0] src, input logic we,
                     input logic sel, input logic [1:0] d, input string tag);
    logic [1:0] seen;
    logic       low_exp;
    hcount  = 8'(h);
    dli_req = src[1];
    vbl_req = src[0];
    wr_en   = we;
    wr_sel  = sel;
    wr_data = d;
    seen    = win_at(h) ? src : 2'b00;
    low_exp = (seen & en_m) != 2'b00;
    st_m    = (we && sel) ? seen : (st_m | seen);
    if (we && !sel) en_m = d;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " nmi_n"}, int'(nmi_n), int'(!low_exp));
    chk({tag, " status"}, int'(nmi_status), int'(st_m));
    if (!nmi_n) low_cnt++;
  endtask

  // A full line with an optional write at hcount wr_h.
  task automatic line(input logic [1:0] src, input int wr_h, input logic sel,
                      input logic [1:0] d, input string tag);
    low_cnt = 0;
    for (int h = 0; h < LINE; h++)
      cyc(h, src, h == wr_h, sel, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 nmi_n after reset", int'(nmi_n), 1);
    chk("R1 status after reset", int'(nmi_status), 0);

    // R1: enables start cleared, so active sources make no pulse
    line(2'b11, -1, 1'b0, 2'b00, "R1");
    chk("R1 no pulse while disabled", low_cnt, 0);
    line(2'b00, 0, 1'b1, 2'b00, "R8");

    // R2 R3 R4 R7: every enable x source combination over a full line
    for (int e = 0; e < 4; e++) begin
      for (int s = 0; s < 4; s++) begin
        line(2'(s), 0, 1'b0, 2'(e), "R3");
        chk("R2 pulse length", low_cnt, ((s & e) != 0) ? 2 : 0);
        chk("R7 status after line", int'(nmi_status), s);
        line(2'b00, 0, 1'b1, 2'b00, "R8");
      end
    end

    // R5: disabling write swept across the window (display-list source)
    for (int w = 3; w <= 9; w++) begin
      line(2'b00, 0, 1'b0, 2'b11, "R4");
      line(2'b10, w, 1'b0, 2'b00, "R5");
      chk("R5 pulse after disabling write", low_cnt,
          int'(w >= TRIG) + int'(w >= TRIG + 1));
    end

    // R6: enabling write swept across the window (vertical-blank source)
    for (int w = 3; w <= 9; w++) begin
      line(2'b00, 0, 1'b0, 2'b00, "R4");
      line(2'b01, w, 1'b0, 2'b01, "R6");
      chk("R6 pulse after enabling write", low_cnt,
          int'(w < TRIG) + int'(w < TRIG + 1));
    end

    // R8: set in the same cycle wins over a clear
    line(2'b00, 0, 1'b0, 2'b00, "R8");
    line(2'b01, TRIG, 1'b1, 2'b11, "R8");
    chk("R8 set beats clear", int'(nmi_status), 1);
    // R8: clear outside window empties status
    line(2'b00, 20, 1'b1, 2'b00, "R8");
    chk("R8 clear outside window", int'(nmi_status), 0);
    // R8: a clear write does not touch the enable register
    line(2'b00, 0, 1'b0, 2'b11, "R4");
    line(2'b00, 0, 1'b1, 2'b00, "R8");
    line(2'b10, -1, 1'b0, 2'b00, "R8");
    chk("R8 enable kept after clear write", low_cnt, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule